// File: doc/BRIEF.md
# UART FIFO Interrupt Generator

This block turns the fill state of one serial channel's receive and transmit FIFOs into interrupt requests. It watches the two fill counts, the programmed thresholds and the access pulses around the FIFOs. From them it keeps one sticky status flag for receive and one for transmit. The flags are gated by a mask register and drive a receive line, a transmit line and a combined line, so an interrupt controller can take either the separate requests or the single merged one.

Two operating modes are supported. In buffered mode the FIFOs hold 16 entries and the flags follow threshold crossings. In single-slot mode each direction holds one character and the flags follow the individual accesses. The transmit flag reacts to a downward crossing and not to a level. An idle, never-written transmitter therefore raises nothing after reset. Every flag clears either through the normal FIFO traffic or through a write-one-to-clear port.

Top module: `uart_fifo_irq`

## Requirements
- R1: In buffered mode (`fifo_en`=1) the receive flag (status bit 0) sets in the cycle after `rx_level` first reaches or exceeds the threshold selected by `rx_trig_sel`. Code 0 selects a quarter of the depth, 1 a half, 2 three quarters and 3 seven eighths (4, 8, 12, 14 of 16).
- R2: In buffered mode the receive flag clears in the cycle after `rx_level` is below the threshold.
- R3: In single-slot mode (`fifo_en`=0) an `rx_push` pulse sets the receive flag and an `rx_pop` pulse clears it. When both arrive together, the flag is set.
- R4: After reset the transmit flag (status bit 1) stays low while `tx_level` never rises above the transmit threshold, whatever that level is.
- R5: In buffered mode the transmit flag sets in the cycle after `tx_level` moves from above the threshold (same coding as R1, via `tx_trig_sel`) to at or below it. It clears in the cycle after `tx_level` is above the threshold.
- R6: In single-slot mode a `tx_pop` pulse (the character leaves the slot) sets the transmit flag and a `tx_push` pulse clears it.
- R7: Writing `clr_we` with a 1 in a bit of `clr_wdata` clears that status bit on the next cycle and leaves the other bit untouched. A set event in the same cycle wins over the clear.
- R8: Raw status is kept whatever the mask. `mask_we` loads `mask_wdata`. `masked_status` equals raw AND mask. `rx_irq` is masked bit 0 and `tx_irq` is masked bit 1.
- R9: `irq` is high exactly when any masked status bit is high.
- R10: Reset clears both status bits, both mask bits and the transmit crossing history, so every output reads zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = buffered mode, 0 = single-slot mode |
| rx_level | input | 5 | Receive FIFO fill count |
| tx_level | input | 5 | Transmit FIFO fill count |
| rx_trig_sel | input | 2 | Receive threshold code |
| tx_trig_sel | input | 2 | Transmit threshold code |
| rx_push | input | 1 | Received character stored (pulse) |
| rx_pop | input | 1 | Receive data read (pulse) |
| tx_push | input | 1 | Transmit data written (pulse) |
| tx_pop | input | 1 | Transmitter took a character (pulse) |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 2 | Mask value, bit 0 receive, bit 1 transmit |
| clr_we | input | 1 | Clear register write strobe |
| clr_wdata | input | 2 | Write-one-to-clear bits |
| raw_status | output | 2 | Unmasked flags |
| masked_status | output | 2 | Flags AND mask |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |
| irq | output | 1 | Combined interrupt |

## Verification
The bench uses the default depth of 16, so every fill count from 0 to 16 is reachable in a few cycles. Ramps up and down sweep all four threshold codes for both directions, which covers the arrival at each threshold and the departure from it. All four mask values are exercised with both flags set, and single-slot collisions of set and clear are driven on purpose.

// File: rtl/uirq_pkg.sv
`timescale 1ns/1ps
package uirq_pkg;

  localparam int unsigned NUM_SRC = 2;

  typedef enum int unsigned {
    SRC_RX = 0,
    SRC_TX = 1
  } src_e;

  // Threshold in entries for a 2-bit code and a given FIFO depth.
  function automatic int unsigned trig_entries(int unsigned depth, logic [1:0] code);
    case (code)
      2'd0:    return depth / 4;
      2'd1:    return depth / 2;
      2'd2:    return (3 * depth) / 4;
      default: return (7 * depth) / 8;
    endcase
  endfunction

  // Next value of a sticky flag: a set event dominates any clear.
  function automatic logic next_flag(logic cur, logic set_ev, logic auto_clr, logic sw_clr);
    return set_ev | (cur & ~auto_clr & ~sw_clr);
  endfunction

endpackage

// File: rtl/uirq_rx_detect.sv
`timescale 1ns/1ps
module uirq_rx_detect
  import uirq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] level,
  input  logic [1:0]       trig_sel,
  input  logic             push,
  input  logic             pop,
  output logic             set_ev,
  output logic             auto_clr
);

  logic [LVL_W-1:0] trig;
  logic             at_or_above;
  logic             above_q;

  assign trig        = LVL_W'(trig_entries(DEPTH, trig_sel));
  assign at_or_above = (level >= trig);

  always_ff @(posedge clk) begin
    if (!rst_n) above_q <= 1'b0;
    else        above_q <= at_or_above;
  end

  always_comb begin
    if (fifo_en) begin
      set_ev   = at_or_above & ~above_q;
      auto_clr = ~at_or_above;
    end else begin
      set_ev   = push;
      auto_clr = pop;
    end
  end

  // R1
  rx_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && set_ev && $past(rst_n)) |-> ($past(level) < $past(trig)));

endmodule

// File: rtl/uirq_tx_detect.sv
`timescale 1ns/1ps
module uirq_tx_detect
  import uirq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] level,
  input  logic [1:0]       trig_sel,
  input  logic             push,
  input  logic             pop,
  output logic             set_ev,
  output logic             auto_clr
);

  logic [LVL_W-1:0] trig;
  logic             at_or_below;
  logic             below_q;

  assign trig        = LVL_W'(trig_entries(DEPTH, trig_sel));
  assign at_or_below = (level <= trig);

  // History resets to "already low" so no crossing can appear before a fill.
  always_ff @(posedge clk) begin
    if (!rst_n) below_q <= 1'b1;
    else        below_q <= at_or_below;
  end

  always_comb begin
    if (fifo_en) begin
      set_ev   = at_or_below & ~below_q;
      auto_clr = ~at_or_below;
    end else begin
      set_ev   = pop;
      auto_clr = push;
    end
  end

  // R5
  tx_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && set_ev && $past(rst_n)) |-> ($past(level) > $past(trig)));

endmodule

// File: rtl/uirq_status.sv
`timescale 1ns/1ps
module uirq_status
  import uirq_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] auto_clr,
  input  logic         clr_we,
  input  logic [N-1:0] clr_wdata,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] raw_q,
  output logic [N-1:0] mask_q
);

  logic [N-1:0] sw_clr;
  assign sw_clr = clr_we ? clr_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) raw_q[i] <= 1'b0;
      else        raw_q[i] <= next_flag(raw_q[i], set_ev[i], auto_clr[i], sw_clr[i]);
    end

    // R7
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr[i] && !set_ev[i]) |=> !raw_q[i]);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> raw_q[i]);

    // R2
    auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_clr[i] && !set_ev[i]) |=> !raw_q[i]);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_ev[i] && !auto_clr[i] && !sw_clr[i]) |=> (raw_q[i] == $past(raw_q[i])));
  end

  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_wdata)));

endmodule

// File: rtl/uart_fifo_irq.sv
`timescale 1ns/1ps
module uart_fifo_irq
  import uirq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [1:0]       rx_trig_sel,
  input  logic [1:0]       tx_trig_sel,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             tx_push,
  input  logic             tx_pop,
  input  logic             mask_we,
  input  logic [1:0]       mask_wdata,
  input  logic             clr_we,
  input  logic [1:0]       clr_wdata,
  output logic [1:0]       raw_status,
  output logic [1:0]       masked_status,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic             irq
);

  logic [NUM_SRC-1:0] set_ev;
  logic [NUM_SRC-1:0] auto_clr;
  logic [NUM_SRC-1:0] raw_q;
  logic [NUM_SRC-1:0] mask_q;

  uirq_rx_detect #(.DEPTH(DEPTH)) i_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .level    (rx_level),
    .trig_sel (rx_trig_sel),
    .push     (rx_push),
    .pop      (rx_pop),
    .set_ev   (set_ev[SRC_RX]),
    .auto_clr (auto_clr[SRC_RX])
  );

  uirq_tx_detect #(.DEPTH(DEPTH)) i_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .level    (tx_level),
    .trig_sel (tx_trig_sel),
    .push     (tx_push),
    .pop      (tx_pop),
    .set_ev   (set_ev[SRC_TX]),
    .auto_clr (auto_clr[SRC_TX])
  );

  uirq_status #(.N(NUM_SRC)) i_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_ev     (set_ev),
    .auto_clr   (auto_clr),
    .clr_we     (clr_we),
    .clr_wdata  (clr_wdata),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .raw_q      (raw_q),
    .mask_q     (mask_q)
  );

  assign raw_status    = raw_q;
  assign masked_status = raw_q & mask_q;
  assign rx_irq        = masked_status[SRC_RX];
  assign tx_irq        = masked_status[SRC_TX];
  assign irq           = |masked_status;

  // R4
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) == 1'b0) |-> (raw_status == 2'b00));

endmodule

// File: tb/test_uart_fifo_irq.sv
`timescale 1ns/1ps
module test_uart_fifo_irq;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0;
  logic [4:0] rx_level = '0, tx_level = '0;
  logic [1:0] rx_trig_sel = '0, tx_trig_sel = '0;
  logic       rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
  logic       mask_we = 0, clr_we = 0;
  logic [1:0] mask_wdata = '0, clr_wdata = '0;
  logic [1:0] raw_status, masked_status;
  logic       rx_irq, tx_irq, irq;

  int checks = 0;
  int failures = 0;

  // model state
  logic [1:0] m_raw = '0, m_mask = '0;
  logic       m_rxh = 1'b0, m_txh = 1'b1;

  always #2.5 clk = ~clk;

  uart_fifo_irq i_uart_fifo_irq (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .rx_level(rx_level), .tx_level(tx_level),
    .rx_trig_sel(rx_trig_sel), .tx_trig_sel(tx_trig_sel),
    .rx_push(rx_push), .rx_pop(rx_pop), .tx_push(tx_push), .tx_pop(tx_pop),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .raw_status(raw_status), .masked_status(masked_status),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .irq(irq)
  );

  // Threshold restated as eighths of the depth: codes give 2,4,6,7 eighths.
  function automatic int thr(input logic [1:0] code);
    int eighths;
    eighths = (code == 2'd3) ? 7 : 2 * (int'(code) + 1);
    return (DEPTH * eighths) / 8;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input string tag);
    logic rx_hi, tx_lo, s0, c0, s1, c1;
    logic [1:0] sw;
    rx_hi = (int'(rx_level) >= thr(rx_trig_sel));
    tx_lo = (int'(tx_level) <= thr(tx_trig_sel));
    if (fifo_en) begin
      s0 = rx_hi && !m_rxh; c0 = !rx_hi;
      s1 = tx_lo && !m_txh; c1 = !tx_lo;
    end else begin
      s0 = rx_push; c0 = rx_pop;
      s1 = tx_pop;  c1 = tx_push;
    end
    sw = clr_we ? clr_wdata : 2'b00;
    @(posedge clk);
    @(negedge clk);
    m_raw[0] = s0 | (m_raw[0] & !c0 & !sw[0]);
    m_raw[1] = s1 | (m_raw[1] & !c1 & !sw[1]);
    if (mask_we) m_mask = mask_wdata;
    m_rxh = rx_hi;
    m_txh = tx_lo;
    chk(tag, raw_status, m_raw);
    chk("R8", masked_status, m_raw & m_mask);
    chk("R8", rx_irq, m_raw[0] & m_mask[0]);
    chk("R8", tx_irq, m_raw[1] & m_mask[1]);
    chk("R9", irq, (m_raw & m_mask) != 0);
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    mask_we = 0; clr_we = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: everything low after reset
    chk("R10", raw_status, 0);
    chk("R10", masked_status, 0);
    chk("R10", irq, 0);
    // R10: mask reset to zero, so a raw flag does not reach the lines
    rx_push = 1; tick("R10");
    chk("R10", rx_irq, 0);
    clr_we = 1; clr_wdata = 2'b01; tick("R7");
    mask_we = 1; mask_wdata = 2'b11; tick("R8");

    fifo_en = 1'b1;
    for (int c = 0; c < 4; c++) begin
      rx_trig_sel = 2'(c);
      for (int l = 0; l <= DEPTH; l++) begin rx_level = 5'(l); tick("R1"); end
      for (int l = DEPTH; l >= 0; l--) begin rx_level = 5'(l); tick("R2"); end
    end

    for (int c = 0; c < 4; c++) begin
      tx_trig_sel = 2'(c);
      for (int l = 0; l <= thr(2'(c)); l++) begin
        tx_level = 5'(l); tick("R4");
        chk("R4", raw_status[1], 0);
      end
      for (int l = thr(2'(c)); l >= 0; l--) begin tx_level = 5'(l); tick("R4"); end
    end

    for (int c = 0; c < 4; c++) begin
      tx_trig_sel = 2'(c);
      for (int l = 0; l <= DEPTH; l++) begin tx_level = 5'(l); tick("R5"); end
      for (int l = DEPTH; l >= 0; l--) begin tx_level = 5'(l); tick("R5"); end
      chk("R5", raw_status[1], 1);
    end
    clr_we = 1; clr_wdata = 2'b10; tick("R7");

    fifo_en = 1'b0;
    tick("R3");
    rx_push = 1; tick("R3");
    chk("R3", rx_irq, 1);
    tick("R3");
    rx_pop = 1; tick("R3");
    chk("R3", rx_irq, 0);
    rx_push = 1; rx_pop = 1; tick("R3");
    chk("R3", raw_status[0], 1);
    rx_pop = 1; tick("R3");

    tx_pop = 1; tick("R6");
    chk("R6", tx_irq, 1);
    tick("R6");
    tx_push = 1; tick("R6");
    chk("R6", tx_irq, 0);
    tx_pop = 1; clr_we = 1; clr_wdata = 2'b10; tick("R7");
    chk("R7", raw_status[1], 1);
    clr_we = 1; clr_wdata = 2'b10; tick("R7");
    chk("R7", raw_status[1], 0);

    rx_push = 1; tx_pop = 1; tick("R7");
    clr_we = 1; clr_wdata = 2'b01; tick("R7");
    chk("R7", raw_status, 2'b10);
    rx_push = 1; tick("R7");
    clr_we = 1; clr_wdata = 2'b10; tick("R7");
    chk("R7", raw_status, 2'b01);

    tx_pop = 1; tick("R8");
    for (int m = 0; m < 4; m++) begin
      mask_we = 1; mask_wdata = 2'(m); tick("R8");
      chk("R8", raw_status, 2'b11);
      tick("R8");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule